// File: doc/BRIEF.md
# Rectangle Block Transfer Engine

This block moves rectangles of bytes inside one frame buffer. Software programs a set of 32-bit memory-mapped registers: line pitches, a pattern base, a source base, a destination base and a control word holding a raster operation code and two direction flags. Writing the size register then launches the operation. The engine has two modes. It can fill a destination rectangle by tiling an 8×8 byte pattern, or it can copy a source rectangle to a destination rectangle.

The engine talks to memory through a simple synchronous byte port, where read data returns one clock after the request. Each destination byte takes two clocks: a read of the source or pattern byte, then the write of that byte to the destination. The direction flags let software pick the order of the walk. Lines can be walked right-to-left, and the rectangle can be walked bottom-to-top, so copies between overlapping rectangles give the same result as copying from an untouched snapshot. Bit 31 of the control register reads as 1 for as long as an operation runs.

Top module: `blit_engine`

## Requirements
- R1: After synchronous reset, every register reads 0, the busy bit (control bit 31) is 0, and no memory request is made.
- R2: Register byte offsets are 0x00 pitch, 0x10 control, 0x14 pattern base, 0x18 source base, 0x1C destination base and 0x20 size. Pitch and size read back as written. Source and destination read back their low 22 bits. The pattern base reads back bits 21:3, with bits 2:0 forced to zero. Control reads back bits 9:0 as written, bit 31 as busy, and 0 in bits 30:10.
- R3: Writing the size register (height in bits 31:16, width in bytes in bits 15:0) while idle, with both fields nonzero, sets busy from the next clock. Each destination byte costs exactly one read request followed by one write request. Busy clears after exactly 2·W·H clocks.
- R4: If the raster code in control bits 7:0 is anything other than 0xCC (for example 0xF0), the engine fills from the pattern. The destination byte at column x and line y of the rectangle gets the byte at aligned pattern base + (y mod 8)·8 + (x mod 8).
- R5: Raster code 0xCC copies. The byte at source base + y·(source pitch) + x goes to destination base + y·(destination pitch) + x. The source pitch is pitch register bits 31:16 and the destination pitch is bits 15:0, both in bytes.
- R6: With control bit 8 set, each line is walked from its last byte to its first. A copy to a destination that overlaps the source further right on the same lines then gives the same result as a copy from an unmodified snapshot.
- R7: With control bit 9 set, lines are walked from the last to the first. A copy to a destination that overlaps the source lower down then gives the same result as a copy from an unmodified snapshot.
- R8: No memory byte outside the destination rectangle is written.
- R9: A write to the size register while busy is ignored. The running operation keeps its length and result, and the size register keeps its earlier value.
- R10: A size write with zero width or zero height finishes at once. Busy never rises and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 22 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one clock after a read request |

## Verification
The assertions check, on every clock, the things that hold whatever the operands are. A write request always follows a read request and is never followed at once by another write. A new start is never accepted while the engine is running. A zero-sized launch never raises busy. The column offset never leaves the latched width. Only the bench's scenarios can show that the right bytes land in the right places: the pattern tiling, the two pitches, the memmove-like results of the reversed walks on overlapping rectangles, the 2·W·H duration, and that no byte outside the rectangle changes. To do this, the bench compares the whole memory against a model that it computes itself.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int unsigned BLIT_AW       = 22;
    localparam int unsigned REG_AW        = 6;
    localparam int unsigned DIM_W         = 16;
    localparam int unsigned DATA_W        = 8;
    localparam int unsigned PAT_LOG2      = 3;
    localparam int unsigned CTRL_W        = 10;

    localparam logic [REG_AW-1:0] OFF_PITCH = 6'h00;
    localparam logic [REG_AW-1:0] OFF_CTRL  = 6'h10;
    localparam logic [REG_AW-1:0] OFF_PAT   = 6'h14;
    localparam logic [REG_AW-1:0] OFF_SRC   = 6'h18;
    localparam logic [REG_AW-1:0] OFF_DST   = 6'h1C;
    localparam logic [REG_AW-1:0] OFF_SIZE  = 6'h20;

    localparam logic [7:0] ROP_PAT_COPY = 8'hF0;
    localparam logic [7:0] ROP_SRC_COPY = 8'hCC;

    localparam int unsigned CTRL_REVX_BIT = 8;
    localparam int unsigned CTRL_REVY_BIT = 9;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_FETCH,
        SEQ_STORE
    } seq_state_e;

    typedef struct packed {
        logic [BLIT_AW-1:0] src_base;
        logic [BLIT_AW-1:0] pat_base;
        logic [BLIT_AW-1:0] dst_base;
        logic [DIM_W-1:0]   src_pitch;
        logic [DIM_W-1:0]   dst_pitch;
        logic [DIM_W-1:0]   width;
        logic [DIM_W-1:0]   height;
        logic [7:0]         rop;
        logic               rev_x;
        logic               rev_y;
    } blit_cfg_t;

    function automatic logic [2*PAT_LOG2-1:0] pat_offset(
        input logic [PAT_LOG2-1:0] row,
        input logic [PAT_LOG2-1:0] col
    );
        return {row, col};
    endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    output blit_cfg_t         cfg,
    output logic              start,
    output logic [31:0]       reg_rdata
);

    logic [31:0]        pitch_q;
    logic [31:0]        size_q;
    logic [BLIT_AW-1:0] pat_q;
    logic [BLIT_AW-1:0] src_q;
    logic [BLIT_AW-1:0] dst_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic               size_wr;

    assign size_wr = reg_we && (reg_addr == OFF_SIZE) && !busy;
    assign start   = size_wr && (|reg_wdata[2*DIM_W-1:DIM_W]) && (|reg_wdata[DIM_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            pitch_q <= '0;
            size_q  <= '0;
            pat_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            ctrl_q  <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                OFF_PITCH: pitch_q <= reg_wdata;
                OFF_CTRL:  ctrl_q  <= reg_wdata[CTRL_W-1:0];
                OFF_PAT:   pat_q   <= {reg_wdata[BLIT_AW-1:PAT_LOG2], {PAT_LOG2{1'b0}}};
                OFF_SRC:   src_q   <= reg_wdata[BLIT_AW-1:0];
                OFF_DST:   dst_q   <= reg_wdata[BLIT_AW-1:0];
                OFF_SIZE:  if (!busy) size_q <= reg_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        cfg.src_base  = src_q;
        cfg.pat_base  = pat_q;
        cfg.dst_base  = dst_q;
        cfg.src_pitch = pitch_q[2*DIM_W-1:DIM_W];
        cfg.dst_pitch = pitch_q[DIM_W-1:0];
        cfg.width     = size_wr ? reg_wdata[DIM_W-1:0] : size_q[DIM_W-1:0];
        cfg.height    = size_wr ? reg_wdata[2*DIM_W-1:DIM_W] : size_q[2*DIM_W-1:DIM_W];
        cfg.rop       = ctrl_q[7:0];
        cfg.rev_x     = ctrl_q[CTRL_REVX_BIT];
        cfg.rev_y     = ctrl_q[CTRL_REVY_BIT];
    end

    always_comb begin
        unique case (reg_addr)
            OFF_PITCH: reg_rdata = pitch_q;
            OFF_CTRL:  reg_rdata = {busy, {(31-CTRL_W){1'b0}}, ctrl_q};
            OFF_PAT:   reg_rdata = 32'(pat_q);
            OFF_SRC:   reg_rdata = 32'(src_q);
            OFF_DST:   reg_rdata = 32'(dst_q);
            OFF_SIZE:  reg_rdata = size_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/blit_line_ptr.sv
module blit_line_ptr
    import blit_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               advance,
    input  logic [BLIT_AW-1:0] base,
    input  logic [DIM_W-1:0]   pitch,
    input  logic [DIM_W-1:0]   height,
    input  logic               rev,
    output logic [BLIT_AW-1:0] ptr
);

    logic [BLIT_AW-1:0] pitch_l;
    logic               rev_l;
    logic [BLIT_AW-1:0] span;

    assign span = BLIT_AW'(height - DIM_W'(1)) * BLIT_AW'(pitch);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            pitch_l <= '0;
            rev_l   <= 1'b0;
        end else if (load) begin
            ptr     <= rev ? (base + span) : base;
            pitch_l <= BLIT_AW'(pitch);
            rev_l   <= rev;
        end else if (advance) begin
            ptr     <= rev_l ? (ptr - pitch_l) : (ptr + pitch_l);
        end
    end

endmodule

// File: rtl/blit_walker.sv
module blit_walker
    import blit_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   height,
    input  logic               rev_x,
    input  logic               rev_y,
    input  logic [BLIT_AW-1:0] src_base,
    input  logic [BLIT_AW-1:0] dst_base,
    input  logic [BLIT_AW-1:0] pat_base,
    input  logic [DIM_W-1:0]   src_pitch,
    input  logic [DIM_W-1:0]   dst_pitch,
    output logic [BLIT_AW-1:0] src_addr,
    output logic [BLIT_AW-1:0] dst_addr,
    output logic [BLIT_AW-1:0] pat_addr,
    output logic               last
);

    localparam int unsigned NPTR = 2;

    logic [DIM_W-1:0]    w_l;
    logic                rev_x_l;
    logic                rev_y_l;
    logic [BLIT_AW-1:0]  pat_l;
    logic [DIM_W-1:0]    x_idx;
    logic [DIM_W-1:0]    x_left;
    logic [DIM_W-1:0]    y_left;
    logic [PAT_LOG2-1:0] y_ph;
    logic                line_step;

    logic [BLIT_AW-1:0]  base_v  [NPTR];
    logic [DIM_W-1:0]    pitch_v [NPTR];
    logic [BLIT_AW-1:0]  ptr_v   [NPTR];

    assign base_v[0]  = src_base;
    assign base_v[1]  = dst_base;
    assign pitch_v[0] = src_pitch;
    assign pitch_v[1] = dst_pitch;

    assign line_step = step && (x_left == '0);
    assign last      = (x_left == '0) && (y_left == '0);

    for (genvar g = 0; g < NPTR; g++) begin : g_line
        blit_line_ptr u_ptr (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .advance (line_step),
            .base    (base_v[g]),
            .pitch   (pitch_v[g]),
            .height  (height),
            .rev     (rev_y),
            .ptr     (ptr_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_l     <= '0;
            rev_x_l <= 1'b0;
            rev_y_l <= 1'b0;
            pat_l   <= '0;
            x_idx   <= '0;
            x_left  <= '0;
            y_left  <= '0;
            y_ph    <= '0;
        end else if (load) begin
            w_l     <= width;
            rev_x_l <= rev_x;
            rev_y_l <= rev_y;
            pat_l   <= pat_base;
            x_left  <= width - DIM_W'(1);
            x_idx   <= rev_x ? (width - DIM_W'(1)) : '0;
            y_left  <= height - DIM_W'(1);
            y_ph    <= rev_y ? PAT_LOG2'(height - DIM_W'(1)) : '0;
        end else if (step) begin
            if (x_left != '0) begin
                x_idx  <= rev_x_l ? (x_idx - DIM_W'(1)) : (x_idx + DIM_W'(1));
                x_left <= x_left - DIM_W'(1);
            end else begin
                x_left <= w_l - DIM_W'(1);
                x_idx  <= rev_x_l ? (w_l - DIM_W'(1)) : '0;
                y_left <= y_left - DIM_W'(1);
                y_ph   <= rev_y_l ? (y_ph - PAT_LOG2'(1)) : (y_ph + PAT_LOG2'(1));
            end
        end
    end

    assign src_addr = ptr_v[0] + BLIT_AW'(x_idx);
    assign dst_addr = ptr_v[1] + BLIT_AW'(x_idx);
    assign pat_addr = pat_l + BLIT_AW'(pat_offset(y_ph, x_idx[PAT_LOG2-1:0]));

    AST_X_WITHIN: assert property (@(posedge clk) disable iff (rst)
        step |-> (x_idx < w_l)); // R8

endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic src_sel,
    input  logic last,
    output logic busy,
    output logic load,
    output logic step,
    output logic fetch,
    output logic store,
    output logic use_src
);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            use_src <= 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state   <= SEQ_FETCH;
                        use_src <= src_sel;
                    end
                end
                SEQ_FETCH: state <= SEQ_STORE;
                SEQ_STORE: state <= last ? SEQ_IDLE : SEQ_FETCH;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy  = (state != SEQ_IDLE);
    assign load  = start;
    assign fetch = (state == SEQ_FETCH);
    assign store = (state == SEQ_STORE);
    assign step  = store;

    AST_STORE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_STORE) |-> ($past(state) == SEQ_FETCH)); // R3

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> (state == SEQ_IDLE)); // R9

endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [BLIT_AW-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);

    blit_cfg_t          cfg;
    logic               start;
    logic               busy;
    logic               load;
    logic               step;
    logic               fetch;
    logic               store;
    logic               use_src;
    logic               last;
    logic [BLIT_AW-1:0] src_addr;
    logic [BLIT_AW-1:0] dst_addr;
    logic [BLIT_AW-1:0] pat_addr;

    blit_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .cfg       (cfg),
        .start     (start),
        .reg_rdata (reg_rdata)
    );

    blit_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .src_sel (cfg.rop == ROP_SRC_COPY),
        .last    (last),
        .busy    (busy),
        .load    (load),
        .step    (step),
        .fetch   (fetch),
        .store   (store),
        .use_src (use_src)
    );

    blit_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .width     (cfg.width),
        .height    (cfg.height),
        .rev_x     (cfg.rev_x),
        .rev_y     (cfg.rev_y),
        .src_base  (cfg.src_base),
        .dst_base  (cfg.dst_base),
        .pat_base  (cfg.pat_base),
        .src_pitch (cfg.src_pitch),
        .dst_pitch (cfg.dst_pitch),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .pat_addr  (pat_addr),
        .last      (last)
    );

    assign mem_req   = fetch || store;
    assign mem_we    = store;
    assign mem_addr  = store ? dst_addr : (use_src ? src_addr : pat_addr);
    assign mem_wdata = store ? mem_rdata : '0;

    AST_ZERO_SIZE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && (reg_addr == OFF_SIZE) && !busy &&
         ((reg_wdata[2*DIM_W-1:DIM_W] == '0) || (reg_wdata[DIM_W-1:0] == '0))) |=> !busy); // R10

    AST_NO_BACK_TO_BACK_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R3

endmodule

// File: tb/tb_blit_engine.sv
`timescale 1ns/1ps
module tb_blit_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [21:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  mem  [0:4095];
    logic [7:0]  expm [0:4095];
    logic [7:0]  snap [0:4095];

    int cyc = 0;
    int req_count = 0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    blit_engine dut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            req_count <= req_count + 1;
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:0]];
        end
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            errors++;
            $display("FAIL R3 watchdog expired: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic model(input logic [31:0] ctrl, input int src, input int pat,
                         input int dst, input int sp, input int dp,
                         input int w, input int h);
        for (int i = 0; i < 4096; i++) snap[i] = expm[i];
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                int d;
                int s;
                d = (dst + y * dp + x) & 12'hFFF;
                if (ctrl[7:0] == 8'hCC) s = (src + y * sp + x) & 12'hFFF;
                else s = ((pat & 32'h3FFFF8) + (y % 8) * 8 + (x % 8)) & 12'hFFF;
                expm[d] = snap[s];
            end
        end
    endtask

    task automatic compare_mem(input string req);
        int bad;
        int first;
        bad = 0; first = -1;
        for (int i = 0; i < 4096; i++) begin
            if (mem[i] !== expm[i]) begin
                if (first < 0) first = i;
                bad++;
            end
        end
        if (first < 0) check(1'b1, req, "memory image", 0, 0);
        else check(1'b0, req, $sformatf("memory byte at 0x%0h (%0d bad)", first, bad),
                   mem[first], expm[first]);
    endtask

    task automatic wait_idle(output int t1);
        reg_addr = 6'h10;
        forever begin
            #1;
            if (!reg_rdata[31]) break;
            @(negedge clk);
        end
        t1 = cyc;
    endtask

    task automatic run_op(input logic [31:0] ctrl, input int src, input int pat,
                          input int dst, input int sp, input int dp,
                          input int w, input int h, input string req);
        int r0;
        int t0;
        int t1;
        string treq;
        treq = (w == 0 || h == 0) ? "R10" : "R3";
        reg_write(6'h00, {sp[15:0], dp[15:0]});
        reg_write(6'h14, pat);
        reg_write(6'h18, src);
        reg_write(6'h1C, dst);
        reg_write(6'h10, ctrl);
        model(ctrl, src, pat, dst, sp, dp, w, h);
        r0 = req_count;
        reg_write(6'h20, {h[15:0], w[15:0]});
        t0 = cyc;
        wait_idle(t1);
        check((t1 - t0) == 2 * w * h, treq, "busy duration", t1 - t0, 2 * w * h);
        check((req_count - r0) == 2 * w * h, treq, "memory request count",
              req_count - r0, 2 * w * h);
        compare_mem(req);
    endtask

    initial begin
        logic [31:0] rd;
        int wl [6];
        int hl [4];
        int cw [3];
        int ch [3];
        int t0;
        int t1;
        int r0;
        wl = '{1, 2, 7, 8, 9, 13};
        hl = '{1, 3, 8, 10};
        cw = '{1, 5, 16};
        ch = '{1, 4, 7};

        for (int i = 0; i < 4096; i++) begin
            mem[i]  = 8'(i * 37 + 11);
            expm[i] = 8'(i * 37 + 11);
        end

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        r0 = req_count;
        reg_read(6'h00, rd); check(rd == 0, "R1", "pitch after reset", rd, 0);
        reg_read(6'h10, rd); check(rd == 0, "R1", "control after reset", rd, 0);
        reg_read(6'h14, rd); check(rd == 0, "R1", "pattern after reset", rd, 0);
        reg_read(6'h18, rd); check(rd == 0, "R1", "source after reset", rd, 0);
        reg_read(6'h1C, rd); check(rd == 0, "R1", "destination after reset", rd, 0);
        reg_read(6'h20, rd); check(rd == 0, "R1", "size after reset", rd, 0);
        check(req_count == 0, "R1", "requests since reset", req_count, 0);

        // R2: readback and masking
        reg_write(6'h00, 32'h1234_5678);
        reg_read(6'h00, rd); check(rd == 32'h1234_5678, "R2", "pitch readback", rd, 32'h1234_5678);
        reg_write(6'h14, 32'hFFFF_FFFF);
        reg_read(6'h14, rd); check(rd == 32'h003F_FFF8, "R2", "pattern masking", rd, 32'h003F_FFF8);
        reg_write(6'h18, 32'hFFFF_FFFF);
        reg_read(6'h18, rd); check(rd == 32'h003F_FFFF, "R2", "source readback", rd, 32'h003F_FFFF);
        reg_write(6'h1C, 32'h00AB_CDEF);
        reg_read(6'h1C, rd); check(rd == 32'h002B_CDEF, "R2", "destination readback", rd, 32'h002B_CDEF);
        reg_write(6'h10, 32'hFFFF_FFFF);
        reg_read(6'h10, rd); check(rd == 32'h0000_03FF, "R2", "control readback", rd, 32'h0000_03FF);
        check(req_count == r0, "R2", "requests from register writes", req_count, r0);

        // R4, R8: pattern fill sweep across sizes and walk directions
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [31:0] c;
                c = {22'd0, 2'(a + b), ((a == 3 && b == 2) ? 8'h00 : 8'hF0)};
                run_op(c, 0, 32'h013, 32'h400, 0, 20, wl[a], hl[b], "R4");
            end
        end

        // R5, R8: source copy sweep, all four direction combinations
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                for (int d = 0; d < 4; d++) begin
                    run_op({22'd0, 2'(d), 8'hCC}, 32'h100, 0, 32'h600, 24, 32,
                           cw[a], ch[b], "R5");
                end
            end
        end

        // R6: overlap to the right on the same lines, right-to-left walk
        run_op(32'h1CC, 32'hA00, 0, 32'hA03, 16, 16, 10, 3, "R6");
        // R7: overlap one line down, bottom-to-top walk
        run_op(32'h2CC, 32'hB00, 0, 32'hB10, 16, 16, 8, 5, "R7");
        // R6 and R7 together: overlap down and right
        run_op(32'h3CC, 32'hC00, 0, 32'hC12, 16, 16, 9, 4, "R7");

        // R10: zero width, zero height
        run_op(32'h0CC, 32'h100, 0, 32'hD00, 8, 8, 0, 5, "R10");
        run_op(32'h0F0, 0, 32'h010, 32'hD00, 8, 8, 6, 0, "R10");
        reg_read(6'h10, rd); check(rd[31] == 1'b0, "R10", "busy after zero size", rd[31], 0);

        // R9: size write while busy is ignored
        reg_write(6'h00, {16'd12, 16'd12});
        reg_write(6'h18, 32'h100);
        reg_write(6'h1C, 32'hE00);
        reg_write(6'h10, 32'h0CC);
        model(32'h0CC, 32'h100, 0, 32'hE00, 12, 12, 6, 4);
        r0 = req_count;
        reg_write(6'h20, {16'd4, 16'd6});
        t0 = cyc;
        repeat (4) @(negedge clk);
        reg_write(6'h20, {16'd16, 16'd16});
        wait_idle(t1);
        check((t1 - t0) == 48, "R9", "duration with ignored size write", t1 - t0, 48);
        check((req_count - r0) == 48, "R9", "requests with ignored size write", req_count - r0, 48);
        compare_mem("R9");
        reg_read(6'h20, rd); check(rd == {16'd4, 16'd6}, "R9", "size register kept", rd, {16'd4, 16'd6});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule